// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the 32-bit data-processing unit of a compact 16-bit-encoded RISC core. It takes two operands, an operation select and the current carry flag. It produces a result, a register write enable, a four-bit flag-update mask, and the next negative, zero, carry and overflow flags. The arithmetic group is add, add-with-carry, compare-negative, subtract, subtract-with-carry, negate and compare. The logical group is AND, exclusive-OR, inclusive-OR, bit-clear, move-inverted and test. It also has a multiply that returns the low word of the product. Each group writes its own subset of the flags.

The arithmetic core is purely combinational. A thin registered wrapper holds the architectural flag register and feeds its carry bit back into the core. On every cycle that `in_valid` is high, the wrapper captures the result and updates the flags through the mask. A pipeline or a bench can therefore step the unit one operation per cycle, and chained carry operations behave as they would in the core.

Top module: `fsalu`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `out_valid`, `out_wr_en`, `out_result`, `out_flag_mask` and `flags_q` are all zero. Flag bits are ordered as `flags_q[3]`=N, `[2]`=Z, `[1]`=C, `[0]`=V, and `out_flag_mask` uses the same bit order.
- R2: ADD (op 7) and CMN (op 9) compute a+b. N is result bit 31, Z is set for a zero result, C is the unsigned carry-out and V is the signed overflow of the addition.
- R3: ADC (op 8) computes a+b+C using the registered carry. Its C and V flags are those of the addition of the original a and b with that carry in.
- R4: SUB (op 10) and CMP (op 13) compute a-b. C is 1 exactly when a >= b as unsigned numbers. V is set when a and b differ in sign and the result's sign differs from a.
- R5: SBC (op 11) first forms the adjusted subtrahend b + NOT C, truncated to 32 bits, and then computes a minus that value. C and V use the R4 rules against a and the adjusted subtrahend. With C=0 and b=0xFFFFFFFF, the adjusted subtrahend wraps to 0, so the result is a and C is 1.
- R6: NEG (op 12) computes 0-b and uses the R4 flag rules with a taken as 0.
- R7: AND (op 0), EOR (op 1), ORR (op 2), BIC (op 3, a AND NOT b), MVN (op 4, NOT b) and TST (op 5, a AND b) produce the bitwise results given.
- R8: MUL (op 6) returns the low 32 bits of a*b.
- R9: The logical operations and MUL write only N and Z, with mask 4'b1100. C and V keep their previous values. The arithmetic operations use mask 4'b1111.
- R10: CMP, CMN and TST update the flags but drive `out_wr_en` low. Every other defined operation drives it high.
- R11: Ops 14 and 15 are reserved. They give result 0, `out_wr_en`=0, mask 0, and leave the flags unchanged.
- R12: Outputs and flags update on the clock edge where `in_valid` is high, and are visible from that edge on. `out_valid` is high for exactly the cycles that follow an accepted operation. While `in_valid` is low, the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 4 | Operation select (encodings in R2 to R11) |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 32 | Registered result |
| out_wr_en | output | 1 | Register write-back enable |
| out_flag_mask | output | 4 | Flags written by this operation (NZCV) |
| flags_q | output | 4 | Architectural flags N,Z,C,V |

## Verification
The hardest case to reach is the wrap of the subtract-with-carry subtrahend. It needs the carry flag clear together with an all-ones second operand. Because the carry can only be set through earlier operations at the ports, the stimulus first runs a compare whose borrow clears C, and then issues the subtract-with-carry with b=0xFFFFFFFF. The same carry-setting preambles check that logical operations leave a previously set C and V untouched.

// File: rtl/fsalu_pkg.sv
package fsalu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'd0,
      OP_EOR = 4'd1,
      OP_ORR = 4'd2,
      OP_BIC = 4'd3,
      OP_MVN = 4'd4,
      OP_TST = 4'd5,
      OP_MUL = 4'd6,
      OP_ADD = 4'd7,
      OP_ADC = 4'd8,
      OP_CMN = 4'd9,
      OP_SUB = 4'd10,
      OP_SBC = 4'd11,
      OP_NEG = 4'd12,
      OP_CMP = 4'd13,
      OP_RS0 = 4'd14,
      OP_RS1 = 4'd15
   } op_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;

   localparam logic [3:0] MASK_ALL  = 4'b1111;
   localparam logic [3:0] MASK_NZ   = 4'b1100;
   localparam logic [3:0] MASK_NONE = 4'b0000;

   function automatic logic is_logic_class(input logic [3:0] op);
      return op <= 4'd5;
   endfunction

   function automatic logic is_add_class(input logic [3:0] op);
      return (op == OP_ADD) || (op == OP_ADC) || (op == OP_CMN);
   endfunction

   function automatic logic is_sub_class(input logic [3:0] op);
      return (op >= OP_SUB) && (op <= OP_CMP);
   endfunction

   function automatic logic is_reserved(input logic [3:0] op);
      return op >= OP_RS0;
   endfunction

endpackage

// File: rtl/fsalu_addsub.sv
module fsalu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   input  logic         use_cin,
   output logic [W-1:0] res,
   output logic         c_out,
   output logic         v_out
);

   localparam int WX = W + 1;

   logic [W-1:0] adj;
   logic [WX-1:0] wide;
   logic          add_c;

   // Adjusted subtrahend wraps at W bits before the flags are formed.
   always_comb begin
      add_c = use_cin & cin;
      adj   = b + {{(W-1){1'b0}}, (use_cin & ~cin)};
   end

   always_comb begin
      if (sub) begin
         wide  = {1'b0, a} - {1'b0, adj};
         c_out = ~wide[W];
         v_out = (a[W-1] ^ adj[W-1]) & (wide[W-1] ^ a[W-1]);
      end else begin
         wide  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, add_c};
         c_out = wide[W];
         v_out = ~(a[W-1] ^ b[W-1]) & (wide[W-1] ^ a[W-1]);
      end
      res = wide[W-1:0];
   end

endmodule

// File: rtl/fsalu_logic.sv
module fsalu_logic #(
   parameter int W = 32
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res
);
   import fsalu_pkg::*;

   always_comb begin
      unique case (op_e'(op))
         OP_AND, OP_TST: res = a & b;
         OP_EOR:         res = a ^ b;
         OP_ORR:         res = a | b;
         OP_BIC:         res = a & ~b;
         OP_MVN:         res = ~b;
         default:        res = '0;
      endcase
   end

endmodule

// File: rtl/fsalu_mul.sv
module fsalu_mul #(
   parameter int W         = 32,
   parameter int MUL_ARRAY = 1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res
);

   generate
      if (MUL_ARRAY != 0) begin : g_array
         logic [W-1:0] acc [W+1];
         assign acc[0] = '0;
         for (genvar i = 0; i < W; i++) begin : g_row
            assign acc[i+1] = acc[i] + (b[i] ? (a << i) : '0);
         end
         assign res = acc[W];
      end else begin : g_native
         assign res = a * b;
      end
   endgenerate

endmodule

// File: rtl/fsalu_core.sv
module fsalu_core #(
   parameter int W         = 32,
   parameter int MUL_ARRAY = 1
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [3:0]   flags_cur,
   output logic [W-1:0] result,
   output logic         wr_en,
   output logic [3:0]   mask,
   output logic [3:0]   flags_nxt
);
   import fsalu_pkg::*;

   logic          c_logic, c_add, c_sub, c_rsv;
   logic          as_sub, as_cin;
   logic [W-1:0]  as_a;
   logic [W-1:0]  as_res, lg_res, mu_res;
   logic          as_c, as_v;
   logic [3:0]    raw;

   always_comb begin
      c_logic = is_logic_class(op);
      c_add   = is_add_class(op);
      c_sub   = is_sub_class(op);
      c_rsv   = is_reserved(op);
      as_sub  = c_sub;
      as_cin  = (op == OP_ADC) || (op == OP_SBC);
      as_a    = (op == OP_NEG) ? '0 : a;
   end

   fsalu_addsub #(.W(W)) u_addsub (
      .a       (as_a),
      .b       (b),
      .cin     (flags_cur[FLAG_C]),
      .sub     (as_sub),
      .use_cin (as_cin),
      .res     (as_res),
      .c_out   (as_c),
      .v_out   (as_v)
   );

   fsalu_logic #(.W(W)) u_logic (
      .op  (op),
      .a   (a),
      .b   (b),
      .res (lg_res)
   );

   fsalu_mul #(.W(W), .MUL_ARRAY(MUL_ARRAY)) u_mul (
      .a   (a),
      .b   (b),
      .res (mu_res)
   );

   always_comb begin
      if (c_logic)            result = lg_res;
      else if (op == OP_MUL)  result = mu_res;
      else if (c_add | c_sub) result = as_res;
      else                    result = '0;

      if (c_rsv)                  mask = MASK_NONE;
      else if (c_add | c_sub)     mask = MASK_ALL;
      else                        mask = MASK_NZ;

      wr_en = ~c_rsv && (op != OP_CMP) && (op != OP_CMN) && (op != OP_TST);

      raw[FLAG_N] = result[W-1];
      raw[FLAG_Z] = (result == '0);
      raw[FLAG_C] = as_c;
      raw[FLAG_V] = as_v;

      flags_nxt = (raw & mask) | (flags_cur & ~mask);
   end

endmodule

// File: rtl/fsalu.sv
module fsalu #(
   parameter int DATA_W    = 32,
   parameter int MUL_ARRAY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        in_op,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic              out_wr_en,
   output logic [3:0]        out_flag_mask,
   output logic [3:0]        flags_q
);
   import fsalu_pkg::*;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("fsalu: DATA_W must be at least 8");
      end
      if (MUL_ARRAY != 0 && MUL_ARRAY != 1) begin : g_bad_mul
         $error("fsalu: MUL_ARRAY must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] c_result;
   logic              c_wr_en;
   logic [3:0]        c_mask;
   logic [3:0]        c_flags;

   fsalu_core #(.W(DATA_W), .MUL_ARRAY(MUL_ARRAY)) u_core (
      .op        (in_op),
      .a         (in_a),
      .b         (in_b),
      .flags_cur (flags_q),
      .result    (c_result),
      .wr_en     (c_wr_en),
      .mask      (c_mask),
      .flags_nxt (c_flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_result    <= '0;
         out_wr_en     <= 1'b0;
         out_flag_mask <= '0;
         flags_q       <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result    <= c_result;
            out_wr_en     <= c_wr_en;
            out_flag_mask <= c_mask;
            flags_q       <= c_flags;
         end
      end
   end

   AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(flags_q)); // R12
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R12
   AST_CV_KEPT_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (is_logic_class(in_op) || in_op == OP_MUL))
      |=> (flags_q[1:0] == $past(flags_q[1:0]))); // R9
   AST_NO_WB_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_op == OP_CMP || in_op == OP_CMN || in_op == OP_TST))
      |=> !out_wr_en); // R10
   AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_reserved(in_op))
      |=> (out_flag_mask == 4'b0000 && $stable(flags_q))); // R11
   AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flag_mask[FLAG_Z]) |-> (flags_q[FLAG_Z] == (out_result == '0))); // R2

endmodule

// File: tb/fsalu_tb.sv
module fsalu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  in_op = 4'd0;
   logic [31:0] in_a = '0;
   logic [31:0] in_b = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_wr_en;
   logic [3:0]  out_flag_mask;
   logic [3:0]  flags_q;

   always #5 clk = ~clk;

   fsalu u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
      .out_wr_en(out_wr_en), .out_flag_mask(out_flag_mask), .flags_q(flags_q)
   );

   typedef struct {
      logic [31:0] res;
      logic        wr;
      logic [3:0]  mask;
      logic [3:0]  flags;
      string       tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int failures = 0;
   logic [3:0] mflags = 4'b0000;
   bit monitor_on = 1'b0;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input logic [3:0] f);
      exp_t e;
      logic [32:0] w;
      logic [31:0] adj, sa;
      logic c, v;
      logic [3:0] raw;
      c = 1'b0; v = 1'b0; w = '0;
      e.res = '0; e.mask = 4'b0000; e.wr = 1'b1;
      case (op)
         4'd0, 4'd5: e.res = a & b;
         4'd1: e.res = a ^ b;
         4'd2: e.res = a | b;
         4'd3: e.res = a & ~b;
         4'd4: e.res = ~b;
         4'd6: e.res = a * b;
         4'd7, 4'd8, 4'd9: begin
            w = {1'b0, a} + {1'b0, b} + ((op == 4'd8) ? {32'd0, f[1]} : 33'd0);
            e.res = w[31:0]; c = w[32];
            v = (a[31] == b[31]) && (w[31] != a[31]);
         end
         4'd10, 4'd11, 4'd12, 4'd13: begin
            sa  = (op == 4'd12) ? 32'd0 : a;
            adj = (op == 4'd11) ? b + {31'd0, ~f[1]} : b;
            e.res = sa - adj;
            c = (sa >= adj);
            v = (sa[31] != adj[31]) && (e.res[31] != sa[31]);
         end
         default: begin e.res = '0; e.wr = 1'b0; end
      endcase
      if (op <= 4'd6) e.mask = 4'b1100;
      else if (op <= 4'd13) e.mask = 4'b1111;
      if (op == 4'd5 || op == 4'd9 || op == 4'd13) e.wr = 1'b0;
      raw = {e.res[31], (e.res == 32'd0), c, v};
      e.flags = (raw & e.mask) | (f & ~e.mask);
      return e;
   endfunction

   task automatic drive(input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
      exp_t e;
      @(negedge clk);
      e = model(op, a, b, mflags);
      e.tag = tag;
      mflags = e.flags;
      q.push_back(e);
      in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = 1; i < n; i++) @(negedge clk);
   endtask

   // Scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (monitor_on && out_valid) begin
            if (q.size() == 0) begin
               check("R12", "unexpected out_valid", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(e.tag, "result", out_result, e.res);
               check(e.tag, "wr_en", {31'd0, out_wr_en}, {31'd0, e.wr});
               check(e.tag, "mask", {28'd0, out_flag_mask}, {28'd0, e.mask});
               check(e.tag, "flags", {28'd0, flags_q}, {28'd0, e.flags});
            end
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
      check("R1", "result", out_result, 32'd0);
      check("R1", "flags", {28'd0, flags_q}, 32'd0);
      check("R1", "mask", {28'd0, out_flag_mask}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", "flags after release", {28'd0, flags_q}, 32'd0);
      check("R1", "wr_en after release", {31'd0, out_wr_en}, 32'd0);
      monitor_on = 1'b1;

      // R7 logical ops, back to back
      drive(4'd0, 32'hF0F0_F0F0, 32'hFF00_FF00, "R7");
      drive(4'd1, 32'hF0F0_F0F0, 32'hFF00_FF00, "R7");
      drive(4'd2, 32'hF0F0_F0F0, 32'h0000_000F, "R7");
      drive(4'd3, 32'hFFFF_FFFF, 32'h0F0F_0F0F, "R7");
      drive(4'd4, 32'h1234_5678, 32'h0000_0000, "R7");
      drive(4'd5, 32'hAAAA_AAAA, 32'h5555_5555, "R10");
      // R2 add family
      drive(4'd7, 32'h7FFF_FFFF, 32'h0000_0001, "R2");
      drive(4'd7, 32'hFFFF_FFFF, 32'h0000_0001, "R2");
      drive(4'd9, 32'h8000_0000, 32'h8000_0000, "R10");
      // R9 C and V set above; logic and multiply must keep them
      drive(4'd2, 32'h0000_0000, 32'h8000_0000, "R9");
      drive(4'd6, 32'h0001_0000, 32'h0001_0000, "R9");
      // R8 multiply
      drive(4'd6, 32'h0000_0007, 32'hFFFF_FFFD, "R8");
      drive(4'd6, 32'h1234_5678, 32'h9ABC_DEF0, "R8");
      idle(2);
      // R4 subtract and compare
      drive(4'd13, 32'd5, 32'd3, "R4");
      drive(4'd13, 32'd3, 32'd5, "R4");
      drive(4'd10, 32'h8000_0000, 32'd1, "R4");
      drive(4'd10, 32'd9, 32'd9, "R4");
      // R3 add with carry: set C then clear it
      drive(4'd13, 32'd1, 32'd0, "R3");
      drive(4'd8, 32'hFFFF_FFFF, 32'd0, "R3");
      drive(4'd13, 32'd0, 32'd1, "R3");
      drive(4'd8, 32'h7FFF_FFFF, 32'd0, "R3");
      // R5 subtract with carry
      drive(4'd13, 32'd1, 32'd0, "R5");
      drive(4'd11, 32'd10, 32'd3, "R5");
      drive(4'd13, 32'd0, 32'd1, "R5");
      drive(4'd11, 32'd10, 32'd3, "R5");
      drive(4'd13, 32'd0, 32'd1, "R5");
      drive(4'd11, 32'h1234_0000, 32'hFFFF_FFFF, "R5");
      // R6 negate
      drive(4'd12, 32'hDEAD_BEEF, 32'd0, "R6");
      drive(4'd12, 32'd0, 32'd1, "R6");
      drive(4'd12, 32'd0, 32'h8000_0000, "R6");
      // R11 reserved after flags are non-zero
      drive(4'd14, 32'd1, 32'd2, "R11");
      drive(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11");
      // R12 idle: flags hold, out_valid drops
      idle(5);
      check("R12", "out_valid idle", {31'd0, out_valid}, 32'd0);
      check("R12", "flags idle", {28'd0, flags_q}, {28'd0, mflags});
      check("R12", "scoreboard drained", q.size(), 32'd0);
      finish_run();
   end

endmodule